// File: doc/BRIEF.md
# V.23 FSK Tone Generator

This block produces the digital transmit tone of a 1200 bit/s V.23 frequency-shift-keyed modulator. It runs from a 3.579545 MHz reference clock. It advances a 24-bit phase accumulator once per reference cycle and turns the top phase bits into a signed sine sample through a 256-entry table. The outgoing data bit picks one of two phase increments: mark gives 1300 Hz and space gives 2100 Hz. Changing the bit changes only the step size, so the waveform has no phase jump at a bit boundary.

A two-bit mode word chooses between a low-power off state, normal data transmission, and a constant single-tone state. In the off state the phase is cleared and the output sits at code 0, which is mid-scale for the downstream converter and filter. A settle timer counts reference cycles after the block leaves the off state. It raises a ready flag only once 20 ms (71591 cycles) have gone by, so the surrounding logic knows when the tone can be trusted.

Top module: `v23_tone_gen`

## Requirements
- R1: While rst_n is low, sample_o is 0 and tone_ready_o is 0.
- R2: Mode code 2'b11 (off) and the unused code 2'b00 clear the phase to 0 and hold sample_o at 0 (mid-scale) from the next clock edge. They keep tone_ready_o low.
- R3: Mode code 2'b01 (transmit) adds a phase increment of round(f*2^24/3579545) at each reference edge. f is 1300 Hz (increment 6093) when tx_bit_i is 1 and 2100 Hz (increment 9843) when it is 0, which puts each tone within 3 Hz of nominal.
- R4: Mode code 2'b10 (single tone) always uses the 1300 Hz increment, whatever the value of tx_bit_i.
- R5: A change of tx_bit_i or a change between the two tone modes alters only the increment and never the phase value, so the phase stays continuous.
- R6: In a tone mode, sample_o one edge after the phase held value p equals round(127*sin(2*pi*a/256)) within 1 LSB, where a is p[23:16]. Table entries obey s(a+128) = -s(a).
- R7: Mark and space use the same table, so both reach peak codes of +127 and -127. The code -128 never appears.
- R8: tone_ready_o goes high after SETTLE_CYCLES consecutive edges outside the off codes and then stays high. It falls at the first edge in an off code, and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Mode word; bit 1 is the upper selector and bit 0 the lower (see R2 to R4) |
| tx_bit_i | input | 1 | Data bit: 1 selects mark, 0 selects space |
| sample_o | output | 8 | Signed two's-complement sine sample; 0 is mid-scale |
| tone_ready_o | output | 1 | High once the output has settled after leaving the off state |

## Verification
The assertions assume that mode_i and tx_bit_i change only between clock edges, and that the block is held in an off code while reset is released. The bench drives every input at the falling edge and keeps the off code for several cycles after reset, so the internal reset synchronizer never sees a live tone mode. The settle window is shortened through its parameter so that the rise, the hold and the restart of the ready flag all fit in a short run. The tone runs stay long enough that every table address is visited and its value is compared with an arithmetically computed sine.

// File: rtl/v23_tone_pkg.sv
package v23_tone_pkg;

  typedef enum logic [1:0] {
    MODE_RSVD = 2'b00,
    MODE_TX   = 2'b01,
    MODE_TONE = 2'b10,
    MODE_OFF  = 2'b11
  } tone_mode_e;

  // Rounded phase step for frequency f_hz against the reference clock
  function automatic longint unsigned calc_inc(input longint unsigned f_hz,
                                               input longint unsigned ref_hz,
                                               input int              acc_w);
    return ((f_hz << acc_w) + (ref_hz / 2)) / ref_hz;
  endfunction

  // Rational sine approximation on the half wave, mirrored for the other half
  function automatic int sine_code(input int idx, input int addr_w, input int amp);
    int half;
    int p;
    int prod;
    int num;
    int den;
    int v;
    bit neg;
    half = 1 << (addr_w - 1);
    neg  = (idx >= half);
    p    = neg ? (idx - half) : idx;
    prod = p * (half - p);
    num  = amp * 16 * prod;
    den  = 5 * half * half - 4 * prod;
    v    = (2 * num + den) / (2 * den);
    return neg ? -v : v;
  endfunction

endpackage

// File: rtl/v23_mode_decode.sv
module v23_mode_decode
  import v23_tone_pkg::*;
#(
  parameter int                ACC_W     = 24,
  parameter logic [ACC_W-1:0]  MARK_INC  = '0,
  parameter logic [ACC_W-1:0]  SPACE_INC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             tx_bit_i,
  output logic             run_o,
  output logic [ACC_W-1:0] inc_o
);

  always_comb begin
    run_o = 1'b0;
    inc_o = '0;
    unique case (tone_mode_e'(mode_i))
      MODE_TX: begin
        run_o = 1'b1;
        inc_o = tx_bit_i ? MARK_INC : SPACE_INC;
      end
      MODE_TONE: begin
        run_o = 1'b1;
        inc_o = MARK_INC;
      end
      default: begin
        run_o = 1'b0;
        inc_o = '0;
      end
    endcase
  end

  // R3: only the two legal steps are ever used while a tone runs
  p_inc_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (inc_o == MARK_INC || inc_o == SPACE_INC));

  // R4: single-tone mode ignores the data bit
  p_fixed_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_TONE) |-> (inc_o == MARK_INC));

endmodule

// File: rtl/v23_phase_acc.sv
module v23_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] phase_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    if (run_i) begin
      acc_d = acc_q + inc_i;
    end else begin
      acc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign phase_o = acc_q;

  // R2: off codes leave the phase at zero
  p_phase_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (phase_o == '0));

  // R5: a running tone never jumps back to zero except by wrapping
  p_phase_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && inc_i != '0) |=> (phase_o != $past(phase_o)));

endmodule

// File: rtl/v23_sine_rom.sv
module v23_sine_rom
  import v23_tone_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    idle_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [OUT_W-1:0] sample_o
);

  localparam int ROM_N = 1 << ADDR_W;
  localparam int AMP   = (1 << (OUT_W - 1)) - 1;
  localparam int HALF  = ROM_N / 2;

  logic signed [OUT_W-1:0] rom [ROM_N];
  logic signed [OUT_W-1:0] sample_d;
  logic signed [OUT_W-1:0] sample_q;

  for (genvar i = 0; i < ROM_N; i++) begin : g_rom
    assign rom[i] = OUT_W'(sine_code(i, ADDR_W, AMP));
  end

  always_comb begin
    if (idle_i) begin
      sample_d = '0;
    end else begin
      sample_d = rom[addr_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
    end else begin
      sample_q <= sample_d;
    end
  end

  assign sample_o = sample_q;

  // R2: off codes produce mid-scale one edge later
  p_idle_midscale_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> (sample_o == '0));

  // R6: first half of the wave is never negative, second half never positive
  p_half_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i && int'(addr_i) < HALF) |=> (sample_o >= 0));

  p_half_sign_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i && int'(addr_i) >= HALF) |=> (sample_o <= 0));

  // R7: the most negative code is never emitted
  p_amp_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o != {1'b1, {(OUT_W-1){1'b0}}});

endmodule

// File: rtl/v23_settle_timer.sv
module v23_settle_timer #(
  parameter int SETTLE_CYCLES = 71591
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic ready_o
);

  localparam int               CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_limit;

  assign at_limit = (cnt_q == LIMIT);
  assign cnt_en   = hold_i || !at_limit;

  always_comb begin
    if (hold_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = at_limit;

  // R8: an off code drops the flag at the next edge
  p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !ready_o);

  // R8: once high the flag stays high while the tone runs
  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !hold_i) |=> ready_o);

  // R8: the flag can only rise out of a running interval
  p_ready_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> !$past(hold_i));

endmodule

// File: rtl/v23_tone_gen.sv
module v23_tone_gen
  import v23_tone_pkg::*;
#(
  parameter int REF_HZ        = 3579545,
  parameter int MARK_HZ       = 1300,
  parameter int SPACE_HZ      = 2100,
  parameter int ACC_W         = 24,
  parameter int ADDR_W        = 8,
  parameter int OUT_W         = 8,
  parameter int SETTLE_CYCLES = 71591
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             tx_bit_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             tone_ready_o
);

  localparam logic [ACC_W-1:0] MARK_INC  =
    ACC_W'(calc_inc(longint'(MARK_HZ), longint'(REF_HZ), ACC_W));
  localparam logic [ACC_W-1:0] SPACE_INC =
    ACC_W'(calc_inc(longint'(SPACE_HZ), longint'(REF_HZ), ACC_W));

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    run;
  logic [ACC_W-1:0]        inc;
  logic [ACC_W-1:0]        phase;
  logic signed [OUT_W-1:0] sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  v23_mode_decode #(
    .ACC_W    (ACC_W),
    .MARK_INC (MARK_INC),
    .SPACE_INC(SPACE_INC)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mode_i  (mode_i),
    .tx_bit_i(tx_bit_i),
    .run_o   (run),
    .inc_o   (inc)
  );

  v23_phase_acc #(
    .ACC_W(ACC_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .inc_i  (inc),
    .phase_o(phase)
  );

  v23_sine_rom #(
    .ADDR_W(ADDR_W),
    .OUT_W (OUT_W)
  ) u_rom (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .idle_i  (!run),
    .addr_i  (phase[ACC_W-1 -: ADDR_W]),
    .sample_o(sample)
  );

  v23_settle_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_settle (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .hold_i (!run),
    .ready_o(tone_ready_o)
  );

  assign sample_o = sample;

  // R1: outputs are quiet while the synchronized reset is asserted
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (sample_o == '0 && !tone_ready_o));

endmodule

// File: tb/sim_v23_tone_gen.sv
`timescale 1ns/1ps
module sim_v23_tone_gen;

  localparam int S_CYC = 500;
  localparam int M_INC_EXP = 6093;
  localparam int S_INC_EXP = 9843;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       txb;
  logic [7:0] samp;
  logic       rdy;

  int checks = 0;
  int errors = 0;
  int prints = 0;
  bit done   = 0;

  string cur_req = "R1";

  int  m_acc = 0;
  int  m_cnt = 0;
  int  m_inc;
  int  mark_inc;
  int  space_inc;
  int  obs  [256];
  bit  seen [256];
  int  mk_max = 0, mk_min = 0, sp_max = 0, sp_min = 0;

  v23_tone_gen #(.SETTLE_CYCLES(S_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tx_bit_i(txb),
    .sample_o(samp), .tone_ready_o(rdy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int sin_exp(input int a);
    real r;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * a / 256.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int calc_step(input int f);
    real r;
    r = f * 16777216.0 / 3579545.0;
    return $rtoi(r + 0.5);
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (prints < 20) begin
        $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        prints++;
      end
    end
  endtask

  // One reference cycle: model update at the edge, compare at the falling edge
  task automatic cyc();
    bit run;
    bit zp;
    int exp_s;
    int addr;
    int act;
    @(posedge clk);
    run  = (mode == 2'b01) || (mode == 2'b10);
    zp   = !run;
    addr = (m_acc >> 16) & 255;
    exp_s = run ? sin_exp(addr) : 0;
    m_inc = (mode == 2'b10) ? mark_inc : (txb ? mark_inc : space_inc);
    m_acc = run ? ((m_acc + m_inc) & 24'hFFFFFF) : 0;
    if (zp) m_cnt = 0;
    else if (m_cnt < S_CYC) m_cnt++;
    @(negedge clk);
    act = int'($signed(samp));
    if (run) begin
      check(cur_req, (act - exp_s <= 1) && (exp_s - act <= 1), act, exp_s);
      obs[addr]  = act;
      seen[addr] = 1'b1;
      if (m_inc == mark_inc) begin
        if (act > mk_max) mk_max = act;
        if (act < mk_min) mk_min = act;
      end else begin
        if (act > sp_max) sp_max = act;
        if (act < sp_min) sp_min = act;
      end
    end else begin
      check("R2", act == 0, act, 0);
    end
    check("R8", rdy == (m_cnt == S_CYC), int'(rdy), int'(m_cnt == S_CYC));
  endtask

  task automatic run_seg(input int n, input logic [1:0] md, input logic b, input int flip);
    mode = md;
    txb  = b;
    for (int i = 0; i < n; i++) begin
      if (flip > 0 && i > 0 && (i % flip) == 0) txb = ~txb;
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mark_inc  = calc_step(1300);
    space_inc = calc_step(2100);
    mode  = 2'b11;
    txb   = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      obs[i]  = 0;
      seen[i] = 1'b0;
    end
    // R3: increments come out as the stated values
    check("R3", mark_inc == M_INC_EXP, mark_inc, M_INC_EXP);
    check("R3", space_inc == S_INC_EXP, space_inc, S_INC_EXP);
    repeat (3) @(negedge clk);
    // R1: reset state, even with a tone mode requested
    mode = 2'b01;
    @(negedge clk);
    check("R1", samp == 8'd0, int'(samp), 0);
    check("R1", rdy == 1'b0, int'(rdy), 0);
    mode = 2'b11;
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R2";
    run_seg(6, 2'b11, 1'b1, 0);

    cur_req = "R3";
    run_seg(3000, 2'b01, 1'b1, 0);
    check("R8", rdy == 1'b1, int'(rdy), 1);
    run_seg(3000, 2'b01, 1'b0, 0);

    cur_req = "R5";
    run_seg(2000, 2'b01, 1'b1, 37);

    cur_req = "R4";
    run_seg(2000, 2'b10, 1'b0, 11);
    run_seg(500, 2'b10, 1'b1, 0);

    cur_req = "R5";
    mode = 2'b01;
    for (int k = 0; k < 12; k++) run_seg(50, (k % 2) ? 2'b10 : 2'b01, k[1], 0);

    cur_req = "R2";
    run_seg(20, 2'b00, 1'b1, 0);
    check("R2", rdy == 1'b0, int'(rdy), 0);

    cur_req = "R8";
    run_seg(S_CYC - 1, 2'b01, 1'b0, 0);
    check("R8", rdy == 1'b0, int'(rdy), 0);
    run_seg(1, 2'b11, 1'b0, 0);
    run_seg(S_CYC - 1, 2'b10, 1'b0, 0);
    check("R8", rdy == 1'b0, int'(rdy), 0);
    run_seg(1, 2'b10, 1'b0, 0);
    check("R8", rdy == 1'b1, int'(rdy), 1);
    run_seg(200, 2'b01, 1'b1, 0);
    check("R8", rdy == 1'b1, int'(rdy), 1);
    run_seg(10, 2'b11, 1'b1, 0);

    // R6: table sweep, symmetry and anchor points
    for (int a = 0; a < 256; a++) check("R6", seen[a], int'(seen[a]), 1);
    for (int a = 0; a < 128; a++) check("R6", obs[a + 128] == -obs[a], obs[a + 128], -obs[a]);
    check("R6", obs[0] == 0, obs[0], 0);
    check("R6", obs[64] == 127, obs[64], 127);
    // R7: equal peak levels for mark and space
    check("R7", mk_max == 127, mk_max, 127);
    check("R7", mk_min == -127, mk_min, -127);
    check("R7", sp_max == 127, sp_max, 127);
    check("R7", sp_min == -127, sp_min, -127);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule